// File: doc/BRIEF.md
# Dual-Clock Nine-Bit FIFO with Reset-Selected Write Enables

This block is a first-in first-out buffer of 9-bit words that moves data from a write clock domain to an unrelated read clock domain. Its depth is a parameter, any power of two from 64 to 8192 words. One active-low reset clears both domains. The write side has a primary active-low enable and a shared auxiliary pin. The read side has two active-low enables, and both must be low for a read. An active-low output enable drives the output register onto the data pins or floats them.

While reset is held low, the write domain samples the auxiliary pin, and that sample fixes the operating mode until the next reset. If the pin is sampled high, the part runs in dual-enable mode: the pin becomes a second, active-high write enable, as used when several FIFOs are cascaded for more depth. If the pin is sampled low, the part runs in flag-load mode: the primary enable alone controls array writes, and the pin is left to a neighbouring offset-register block as its load strobe.

Two active-low flags report state. The empty flag is computed in the read domain and the full flag in the write domain. Writes to a full buffer and reads from an empty one are dropped. The read register keeps the last word that was validly read.

Top module: `dual_clock_fifo9`

## Requirements
- R1: The buffer holds exactly DEPTH words. After DEPTH accepted writes with no reads, `full_n` is low by the write-clock edge that stored the last word, and the words come out in the order they were written.
- R2: The operating mode is the level of `wr_aux` at the last write-clock edge of the reset period (high selects dual-enable, low selects flag-load). It does not change until the next reset.
- R3: In dual-enable mode, a word is stored on a rising `wr_clk` edge only when `wr_en_n` is low and `wr_aux` is high.
- R4: In flag-load mode, a word is stored on a rising `wr_clk` edge whenever `wr_en_n` is low, whatever the level of `wr_aux`.
- R5: A word is read into the output register on a rising `rd_clk` edge only when `rd_en_a_n` and `rd_en_b_n` are both low. With either one high, the output and the stored contents stay unchanged.
- R6: After reset, `empty_n` is low, `full_n` is high, and the output register holds zero.
- R7: A write attempted while `full_n` is low stores nothing and leaves the existing contents unchanged.
- R8: A read attempted while `empty_n` is low leaves the output register at the last valid word and does not move the read pointer.
- R9: When `out_en_n` is high, every bit of `dout` is high impedance. When it is low, `dout` carries the output register.
- R10: Writes and reads presented while reset is low have no effect. The buffer is empty when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains; mode is sampled while low |
| wr_en_n | input | 1 | Primary active-low write enable |
| wr_aux | input | 1 | Shared pin: mode select during reset, active-high second write enable in dual-enable mode |
| din | input | DATA_W | Write data |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| out_en_n | input | 1 | Active-low output enable for `dout` |
| dout | output | DATA_W | Output register contents, or high impedance |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| full_n | output | 1 | Active-low full flag (write domain) |

## Verification
The write path is tried with all four combinations of the two write enables in each mode. This separates a design that ignores the auxiliary pin in dual-enable mode from one that wrongly needs it in flag-load mode, and a second reset shows that the mode follows the latest reset sample. The read path is tried with each read enable low on its own and then with both low, which exposes a design that decodes only one of them. A full fill to DEPTH words, followed by an extra write and a complete drain, checks capacity, word order and overflow blocking together. Repeated reads on an empty buffer, followed by one fresh word, show that the output holds its last value and that the read pointer did not slip.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        MODE_FLAG_LOAD = 1'b0,
        MODE_DUAL_EN   = 1'b1
    } wr_mode_e;

    function automatic logic [31:0] gray_of(input logic [31:0] bin);
        return bin ^ (bin >> 1);
    endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_sync
);
    typedef struct packed {
        logic s0;
        logic s1;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s0 = 1'b1;
        sync_d.s1 = sync_q.s0;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign rst_n_sync = sync_q.s1;
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ptr_in,
    output logic [W-1:0] ptr_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d        = stage_q;
        stage_d.meta   = ptr_in;
        stage_d.stable = stage_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign ptr_out = stage_q.stable;
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_go) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_aux,
    input  logic [PTR_W-1:0]  rgray_sync,
    output logic              wr_go,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wgray,
    output logic              full,
    output wr_mode_e          mode
);
    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             full;
    } wst_t;

    wst_t     st_d, st_q;
    wr_mode_e mode_d, mode_q;
    logic     req;
    logic [PTR_W-1:0] full_match;

    always_comb begin
        // Sample the shared pin for as long as this domain is held in reset.
        mode_d = rst_n ? mode_q : (wr_aux ? MODE_DUAL_EN : MODE_FLAG_LOAD);

        if (mode_q == MODE_DUAL_EN) req = !wr_en_n && wr_aux;
        else                        req = !wr_en_n;

        wr_go = rst_n && req && !st_q.full;

        // Full: write pointer one lap ahead of the synchronised read pointer.
        full_match = {~rgray_sync[PTR_W-1 -: 2], rgray_sync[PTR_W-3:0]};

        st_d      = st_q;
        st_d.bin  = st_q.bin + PTR_W'(wr_go);
        st_d.gray = PTR_W'(gray_of(32'(st_d.bin)));
        st_d.full = (st_d.gray == full_match);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign waddr = st_q.bin[ADDR_W-1:0];
    assign wgray = st_q.gray;
    assign full  = st_q.full;
    assign mode  = mode_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic              empty,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic              empty;
        logic [DATA_W-1:0] data;
    } rst_t;

    localparam rst_t RD_RESET = '{bin: '0, gray: '0, empty: 1'b1, data: '0};

    rst_t st_d, st_q;
    logic rd_go;

    always_comb begin
        rd_go      = !rd_en_a_n && !rd_en_b_n && !st_q.empty;

        st_d       = st_q;
        st_d.bin   = st_q.bin + PTR_W'(rd_go);
        st_d.gray  = PTR_W'(dcf_pkg::gray_of(32'(st_d.bin)));
        st_d.empty = (st_d.gray == wgray_sync);
        if (rd_go) st_d.data = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RD_RESET;
        else        st_q <= st_d;
    end

    assign raddr = st_q.bin[ADDR_W-1:0];
    assign rgray = st_q.gray;
    assign empty = st_q.empty;
    assign rdata = st_q.data;
endmodule

// File: rtl/dual_clock_fifo9.sv
module dual_clock_fifo9
    import dcf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 64
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_aux,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] dout,
    output logic              empty_n,
    output logic              full_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    if ((1 << ADDR_W) != DEPTH || DEPTH < 4) begin : g_bad_depth
        $error("DEPTH must be a power of two of at least 4");
    end

    logic              wr_rst_n, rd_rst_n;
    logic              wr_go, wr_full, rd_empty;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wr_gray, rd_gray, wgray_in_rd, rgray_in_wr;
    logic [DATA_W-1:0] mem_rdata, rd_data_q;
    wr_mode_e          wr_mode;
    logic              mode_bit;

    dcf_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .rst_n_sync(wr_rst_n));
    dcf_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .rst_n_sync(rd_rst_n));

    dcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_aux(wr_aux),
        .rgray_sync(rgray_in_wr), .wr_go(wr_go), .waddr(waddr),
        .wgray(wr_gray), .full(wr_full), .mode(wr_mode)
    );

    dcf_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
        .wgray_sync(wgray_in_rd), .mem_rdata(mem_rdata), .raddr(raddr),
        .rgray(rd_gray), .empty(rd_empty), .rdata(rd_data_q)
    );

    dcf_gray_sync #(.W(PTR_W)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .ptr_in(wr_gray), .ptr_out(wgray_in_rd)
    );

    dcf_gray_sync #(.W(PTR_W)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .ptr_in(rd_gray), .ptr_out(rgray_in_wr)
    );

    dcf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wr_clk(wr_clk), .wr_go(wr_go), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(mem_rdata)
    );

    assign mode_bit = (wr_mode == MODE_DUAL_EN);
    assign empty_n  = ~rd_empty;
    assign full_n   = ~wr_full;
    assign dout     = out_en_n ? {DATA_W{1'bz}} : rd_data_q;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int PW = 7,
    parameter int DW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wr_rst_n,
    input logic          rd_rst_n,
    input logic          full_n,
    input logic          empty_n,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray,
    input logic          mode,
    input logic [DW-1:0] rdata
);
    // R7: a full buffer never advances its write pointer
    a_r7_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !full_n |=> $stable(wgray));

    // R8: an empty buffer keeps its read pointer and output word
    a_r8_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !empty_n |=> ($stable(rgray) && $stable(rdata)));

    // R1: the write pointer moves at most one Gray step per edge
    a_r1_wptr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R5: the read pointer moves at most one Gray step per edge
    a_r5_rptr_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R2: the mode latched in reset holds while out of reset
    a_r2_mode_fixed: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $past(wr_rst_n) |-> $stable(mode));

    // R6: read side comes out of reset empty with a zero output word
    a_r6_rd_reset_state: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_rst_n) |-> (!empty_n && rdata == '0));

    // R6: write side comes out of reset not full
    a_r6_wr_reset_state: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(wr_rst_n) |-> full_n);
endmodule

bind dual_clock_fifo9 dcf_checker #(.PW(PTR_W), .DW(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
    .full_n(full_n), .empty_n(empty_n), .wgray(wr_gray), .rgray(rd_gray),
    .mode(mode_bit), .rdata(rd_data_q)
);

// File: tb/dual_clock_fifo9_bench.sv
module dual_clock_fifo9_bench;
    localparam int DW    = 9;
    localparam int DEPTH = 64;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          rst_n = 1'b0, wr_en_n = 1'b1, wr_aux = 1'b1;
    logic [DW-1:0] din = '0;
    logic          rd_en_a_n = 1'b1, rd_en_b_n = 1'b1, out_en_n = 1'b0;
    logic [DW-1:0] dout;
    logic          empty_n, full_n;

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_words [DEPTH];

    dual_clock_fifo9 #(.DATA_W(DW), .DEPTH(DEPTH)) u_dual_clock_fifo9 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .wr_aux(wr_aux), .din(din), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
        .out_en_n(out_en_n), .dout(dout), .empty_n(empty_n), .full_n(full_n)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_cycle(input logic en_n, input logic aux, input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en_n = en_n;
        wr_aux  = aux;
        din     = d;
    endtask

    task automatic rd_cycle(input logic a_n, input logic b_n);
        @(negedge rd_clk);
        rd_en_a_n = a_n;
        rd_en_b_n = b_n;
    endtask

    task automatic settle();
        repeat (8) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    // One read with both enables, result sampled after the read edge
    task automatic read_one(input string req, input logic [DW-1:0] exp);
        rd_cycle(1'b0, 1'b0);
        rd_cycle(1'b1, 1'b1);
        check(req, 16'(dout), 16'(exp));
    endtask

    // Reset with traffic attempted during reset (R10), aux level picks mode (R2)
    task automatic reset_to(input logic aux_level);
        @(negedge wr_clk);
        rst_n = 1'b0; wr_aux = aux_level; wr_en_n = 1'b0; din = 9'h155;
        rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        repeat (6) @(negedge wr_clk);
        rst_n = 1'b1; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        settle();
    endtask

    task automatic t_reset_state();
        reset_to(1'b1);
        check("R6 empty_n after reset", 16'(empty_n), 16'd0);
        check("R10 traffic during reset ignored", 16'(empty_n), 16'd0);
        check("R6 dout after reset", 16'(dout), 16'd0);
        @(negedge wr_clk);
        check("R6 full_n after reset", 16'(full_n), 16'd1);
    endtask

    task automatic t_dual_enables();
        wr_cycle(1'b0, 1'b0, 9'h011);
        wr_cycle(1'b1, 1'b1, 9'h022);
        wr_cycle(1'b1, 1'b0, 9'h000);
        settle();
        check("R3 single enable does not write", 16'(empty_n), 16'd0);
        wr_cycle(1'b0, 1'b1, 9'h0A5);
        wr_cycle(1'b1, 1'b1, 9'h000);
        settle();
        check("R3 both enables write", 16'(empty_n), 16'd1);
        read_one("R3 written word", 9'h0A5);
        settle();
        check("R3 drained", 16'(empty_n), 16'd0);
    endtask

    task automatic t_read_enables();
        wr_cycle(1'b0, 1'b1, 9'h13C);
        wr_cycle(1'b1, 1'b1, 9'h000);
        settle();
        rd_cycle(1'b0, 1'b1);
        rd_cycle(1'b1, 1'b1);
        check("R5 only enable A keeps dout", 16'(dout), 16'h0A5);
        rd_cycle(1'b1, 1'b0);
        rd_cycle(1'b1, 1'b1);
        check("R5 only enable B keeps dout", 16'(dout), 16'h0A5);
        check("R5 word still stored", 16'(empty_n), 16'd1);
        read_one("R5 both enables read", 9'h13C);
        settle();
    endtask

    task automatic t_fill_and_overflow();
        for (int i = 0; i < DEPTH; i++) begin
            exp_words[i] = DW'((i * 37 + 3) % 512);
            wr_cycle(1'b0, 1'b1, exp_words[i]);
        end
        wr_cycle(1'b0, 1'b1, 9'h1FF);
        check("R1 full_n after DEPTH writes", 16'(full_n), 16'd0);
        wr_cycle(1'b1, 1'b1, 9'h000);
        settle();
        @(negedge wr_clk);
        check("R7 full_n held after extra write", 16'(full_n), 16'd0);
        @(negedge rd_clk);
        for (int i = 0; i < DEPTH; i++) begin
            rd_cycle(1'b0, 1'b0);
            if (i > 0) check("R1 order", 16'(dout), 16'(exp_words[i-1]));
        end
        rd_cycle(1'b1, 1'b1);
        check("R1 last word", 16'(dout), 16'(exp_words[DEPTH-1]));
        check("R7 extra word not stored", 16'(empty_n), 16'd0);
        settle();
        @(negedge wr_clk);
        check("R1 full_n clears after drain", 16'(full_n), 16'd1);
    endtask

    task automatic t_underflow();
        repeat (3) rd_cycle(1'b0, 1'b0);
        rd_cycle(1'b1, 1'b1);
        check("R8 dout holds last word", 16'(dout), 16'(exp_words[DEPTH-1]));
        check("R8 still empty", 16'(empty_n), 16'd0);
        wr_cycle(1'b0, 1'b1, 9'h0EE);
        wr_cycle(1'b1, 1'b1, 9'h000);
        settle();
        read_one("R8 pointer unharmed", 9'h0EE);
        settle();
    endtask

    task automatic t_output_enable();
        @(negedge rd_clk);
        out_en_n = 1'b1;
        #1;
        check("R9 dout floats", 16'(dout), {7'd0, {DW{1'bz}}});
        out_en_n = 1'b0;
        #1;
        check("R9 dout driven", 16'(dout), 16'h0EE);
    endtask

    task automatic t_flag_mode();
        reset_to(1'b0);
        check("R6 dout zero after second reset", 16'(dout), 16'd0);
        wr_cycle(1'b0, 1'b0, 9'h101);
        wr_cycle(1'b0, 1'b1, 9'h102);
        wr_cycle(1'b1, 1'b0, 9'h103);
        wr_cycle(1'b1, 1'b1, 9'h000);
        settle();
        read_one("R4 write with aux low", 9'h101);
        read_one("R4 write with aux high", 9'h102);
        settle();
        check("R4 no write without primary enable", 16'(empty_n), 16'd0);
        reset_to(1'b1);
        wr_cycle(1'b0, 1'b0, 9'h0F0);
        wr_cycle(1'b1, 1'b1, 9'h000);
        settle();
        check("R2 dual mode restored by reset", 16'(empty_n), 16'd0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_dual_enables();
        t_read_enables();
        t_fill_and_overflow();
        t_underflow();
        t_output_enable();
        t_flag_mode();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule